// File: doc/BRIEF.md
# Three-wire serial EEPROM command engine

This block is the slave-side command engine of a three-wire serial nonvolatile memory. It watches chip select (`cs`), a serial clock (`sk`) and serial data in (`di`). These pins are sampled with the system clock, and a rising edge of `sk` is found by comparing the pin with its value one cycle earlier.

A command starts with a single 1 bit. Next come a two-bit opcode and an address, and then data for the two write kinds. The engine acts on a register array that stands in for the storage cells. A timed programming cycle is modelled by a counter of system clock cycles. While it runs, the engine reports busy or ready on the serial output, which comes with an output enable.

A strap input picks 16-bit or 8-bit organization. A program-enable input, together with an internal write-enable latch, guards every modifying command.

Top module: `ser_eeprom_slave`

## Requirements
- R1: While `cs` is low, the engine returns to waiting for a start bit, `do_oe` is 0 and `sk` edges have no effect. An instruction cut short by `cs` low leaves the array untouched.
- R2: A programming cycle lasts PROG_CYCLES system clock cycles and runs to completion even if `cs` goes low during it. The array holds the new data once it ends.
- R3: Serial input bits are taken on rising `sk` edges. Read data on `do_out` changes only on rising `sk` edges.
- R4: With `cs` high and no start bit seen, any number of rising `sk` edges with `di` low leave the engine waiting. A later 1 begins a normal command.
- R5: After an instruction has received all of its bits, further `sk` edges (including 1 bits) are ignored until `cs` goes low.
- R6: Once a programming cycle begins, and while `cs` is high, `do_oe` is 1 and `do_out` is 0 while busy and 1 when ready. This status stays until the next accepted start bit.
- R7: When `org` is 1 the array is AW-bit addressed 16-bit words. When `org` is 0 it is (AW+1)-bit addressed bytes. Byte address b maps to word b>>1, with bit 0 = 1 selecting the upper half.
- R8: Erase-all is opcode 00 with the top two address bits 10. The remaining address bits are don't-care, and the command sets every word to all ones.
- R9: When `pe` is 0, no write, erase or bulk command starts a cycle or changes the array. Reads still work.
- R10: Continuing to clock a read past the last data bit outputs the data at the next address, MSB first, with no dummy bit.
- R11: Opcode 10 reads, 01 writes, and 11 erases one location to all ones. Opcode 00 uses the top two address bits: 11 enables writes, 00 disables them, and 01 writes the following data to every location.
- R12: After reset, writing is disabled. Modifying commands neither start a cycle nor change the array until a write-enable command arrives.
- R13: A read drives a 0 dummy bit right after the last address bit, then the data MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, high selects |
| sk | input | 1 | Serial clock, sampled by `clk` |
| di | input | 1 | Serial data in |
| org | input | 1 | 1: 16-bit words, 0: 8-bit bytes |
| pe | input | 1 | Program enable, 0 blocks all changes |
| do_out | output | 1 | Serial data out / ready status |
| do_oe | output | 1 | Output enable for `do_out` |

## Verification
The interesting overlap is the end of a programming cycle arriving while the serial side is doing something else. The bench drops `cs` straight after the last data bit, so the cycle finishes while the part is deselected. It also keeps clocking 1 bits into an instruction that has already finished while the cycle runs. Both cases are judged at the pins: ready status must show once `cs` is high again, no phantom command may start, and a later read must return the programmed value.

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave #(
  parameter int AW = 8,
  parameter int PROG_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  input  logic pe,
  output logic do_out,
  output logic do_oe
);

  localparam int WORDS = 1 << AW;
  localparam int SW = AW + 3;
  localparam int CW = $clog2(SW + 17);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_DONE} st_t;

  st_t st;
  logic sk_q, rise, do_bit, wen, status_on, busy, commit;
  logic [CW-1:0] cnt, alast, dlast;
  logic [SW-1:0] shreg, nx;
  logic [AW:0] addr, a_fld, a_next;
  logic [1:0] opc, pfx;
  logic [15:0] dsr, sdata, d_in;
  logic [PW-1:0] pcnt;
  logic pend_all, pend_org;
  logic [AW:0] pend_a;
  logic [15:0] pend_d;
  logic [15:0] mem [WORDS];

  assign rise   = cs & sk & ~sk_q;
  assign alast  = org ? CW'(AW + 1) : CW'(AW + 2);
  assign dlast  = org ? CW'(15) : CW'(7);
  assign nx     = {shreg[SW-2:0], di};
  assign opc    = org ? nx[AW+1:AW] : nx[AW+2:AW+1];
  assign pfx    = org ? nx[AW-1:AW-2] : nx[AW:AW-1];
  assign a_fld  = org ? {1'b0, nx[AW-1:0]} : nx[AW:0];
  assign a_next = org ? {1'b0, addr[AW-1:0] + 1'b1} : addr + 1'b1;
  assign d_in   = {sdata[14:0], di};
  assign commit = busy && (pcnt == '0);
  assign do_oe  = cs && (st == S_READ || status_on);
  assign do_out = (st == S_READ) ? do_bit : ~busy;

  function automatic logic [15:0] fetch(input logic [AW:0] a, input logic o);
    if (o) return mem[a[AW-1:0]];
    return {a[0] ? mem[a[AW:1]][15:8] : mem[a[AW:1]][7:0], 8'h00};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sk_q <= 1'b0;
      cnt <= '0;
      shreg <= '0;
      addr <= '0;
      dsr <= '0;
      sdata <= '0;
      do_bit <= 1'b0;
      wen <= 1'b0;
      status_on <= 1'b0;
      busy <= 1'b0;
      pcnt <= '0;
      pend_all <= 1'b0;
      pend_org <= 1'b1;
      pend_a <= '0;
      pend_d <= '0;
    end else begin
      sk_q <= sk;
      if (busy) begin
        if (pcnt == '0) busy <= 1'b0;
        else pcnt <= pcnt - 1'b1;
      end
      if (!cs) begin
        st <= S_IDLE;
        cnt <= '0;
      end else if (rise) begin
        case (st)
          S_IDLE: if (di && !busy) begin
            st <= S_CMD;
            cnt <= '0;
            shreg <= '0;
            status_on <= 1'b0;
          end
          S_CMD: begin
            shreg <= nx;
            cnt <= cnt + 1'b1;
            if (cnt == alast) begin
              addr <= a_fld;
              cnt <= '0;
              st <= S_DONE;
              case (opc)
                2'b10: begin
                  st <= S_READ;
                  do_bit <= 1'b0;
                  dsr <= fetch(a_fld, org);
                end
                2'b01: begin
                  st <= S_DATA;
                  pend_all <= 1'b0;
                end
                2'b11: if (wen && pe) begin
                  busy <= 1'b1;
                  pcnt <= PW'(PROG_CYCLES - 1);
                  status_on <= 1'b1;
                  pend_all <= 1'b0;
                  pend_org <= org;
                  pend_a <= a_fld;
                  pend_d <= '1;
                end
                default: case (pfx)
                  2'b11: wen <= 1'b1;
                  2'b00: wen <= 1'b0;
                  2'b01: begin
                    st <= S_DATA;
                    pend_all <= 1'b1;
                  end
                  default: if (wen && pe) begin
                    busy <= 1'b1;
                    pcnt <= PW'(PROG_CYCLES - 1);
                    status_on <= 1'b1;
                    pend_all <= 1'b1;
                    pend_org <= org;
                    pend_d <= '1;
                  end
                endcase
              endcase
            end
          end
          S_DATA: begin
            sdata <= d_in;
            cnt <= cnt + 1'b1;
            if (cnt == dlast) begin
              st <= S_DONE;
              if (wen && pe) begin
                busy <= 1'b1;
                pcnt <= PW'(PROG_CYCLES - 1);
                status_on <= 1'b1;
                pend_org <= org;
                pend_a <= addr;
                pend_d <= org ? d_in : {d_in[7:0], d_in[7:0]};
              end
            end
          end
          S_READ: begin
            do_bit <= dsr[15];
            dsr <= {dsr[14:0], 1'b0};
            cnt <= cnt + 1'b1;
            if (cnt == dlast) begin
              cnt <= '0;
              addr <= a_next;
              dsr <= fetch(a_next, org);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      if (pend_all) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= pend_d;
      end else if (pend_org) begin
        mem[pend_a[AW-1:0]] <= pend_d;
      end else if (pend_a[0]) begin
        mem[pend_a[AW:1]][15:8] <= pend_d[15:8];
      end else begin
        mem[pend_a[AW:1]][7:0] <= pend_d[7:0];
      end
    end
  end

  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> st == S_IDLE);

  a_r2_cycle_persists: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pcnt != '0 |=> busy);

  a_r4_wait_start: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && rise && !di |=> st == S_IDLE);

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cs && st == S_DONE |=> st == S_DONE);

  a_r6_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    status_on && !(st == S_IDLE && rise && di && !busy) |=> status_on);

  a_r9_guarded_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pe) && $past(wen));

  a_r13_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CMD && rise && cnt == alast && opc == 2'b10 |=> !cs || (do_oe && !do_out));

endmodule

// File: tb/ser_eeprom_slave_test.sv
`timescale 1ns/1ps
module ser_eeprom_slave_test;
  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0, org = 1, pe = 1;
  logic do_out, do_oe;
  int checks = 0, fails = 0;

  localparam logic [25:0] VEC [6] = '{
    {1'b1, 9'd10,  16'hA5C3},
    {1'b1, 9'd11,  16'h0F1E},
    {1'b1, 9'd200, 16'h8001},
    {1'b0, 9'd40,  16'h005A},
    {1'b0, 9'd41,  16'h00C7},
    {1'b0, 9'd511, 16'h0033}
  };

  ser_eeprom_slave #(.AW(8), .PROG_CYCLES(40)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org), .pe(pe),
    .do_out(do_out), .do_oe(do_oe));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    di = b;
    repeat (3) @(negedge clk);
    sk = 1;
    repeat (3) @(negedge clk);
    sk = 0;
  endtask

  task automatic desel();
    @(negedge clk);
    cs = 0;
    repeat (4) @(negedge clk);
    cs = 1;
    repeat (2) @(negedge clk);
  endtask

  function automatic int alen();
    return org ? 8 : 9;
  endfunction

  task automatic cmd(input logic [1:0] op, input logic [8:0] a);
    tick(1); tick(op[1]); tick(op[0]);
    for (int i = alen() - 1; i >= 0; i--) tick(a[i]);
  endtask

  task automatic special(input logic [1:0] p);
    logic [8:0] t;
    t = 9'({p}) << (alen() - 2);
    cmd(2'b00, t);
  endtask

  task automatic senddata(input logic [15:0] d);
    for (int i = (org ? 15 : 7); i >= 0; i--) tick(d[i]);
  endtask

  task automatic wait_ready();
    int n;
    n = 0;
    while (!(do_oe && do_out) && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic rd_bits(output logic [15:0] d);
    d = '0;
    for (int i = 0; i < (org ? 16 : 8); i++) begin
      tick(0);
      d = {d[14:0], do_out};
    end
  endtask

  task automatic rdchk(input logic [8:0] a, input logic [15:0] exp, input string req);
    logic [15:0] d;
    cmd(2'b10, a);
    chk(do_oe && !do_out, "R13 dummy bit", {15'd0, do_out}, 16'd0);
    rd_bits(d);
    chk(d == exp, req, d, exp);
    desel();
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    cmd(2'b01, a);
    senddata(d);
    wait_ready();
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (5) @(negedge clk);
    chk(do_oe == 0, "R1 reset hi-z", {15'd0, do_oe}, 16'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    cs = 1;
    repeat (2) @(negedge clk);

    // R12: write before enable starts no cycle
    cmd(2'b01, 9'd5);
    senddata(16'h1234);
    repeat (3) @(negedge clk);
    chk(do_oe == 0, "R12 no cycle while disabled", {15'd0, do_oe}, 16'd0);
    desel();

    special(2'b11);
    desel();
    // R8: erase-all with don't-care tail bits
    cmd(2'b00, 9'b0_1011_0101);
    repeat (2) @(negedge clk);
    chk(do_oe && !do_out, "R6 busy status", {14'd0, do_oe, do_out}, 16'h0002);
    wait_ready();
    chk(do_oe && do_out, "R6 ready status", {14'd0, do_oe, do_out}, 16'h0003);
    desel();
    rdchk(9'd5, 16'hFFFF, "R12 earlier write had no effect");
    rdchk(9'd77, 16'hFFFF, "R8 erase-all");

    // table: write then read back (R3, R11, R7)
    for (int k = 0; k < 6; k++) begin
      org = VEC[k][25];
      desel();
      wr(VEC[k][24:16], VEC[k][15:0]);
      rdchk(VEC[k][24:16], org ? VEC[k][15:0] : {8'h00, VEC[k][7:0]}, "R3 R11 write/read vector");
    end
    org = 1;
    desel();
    rdchk(9'd20, 16'hC75A, "R7 byte halves in word");
    rdchk(9'd255, 16'h33FF, "R7 upper byte of last word");

    // R11 erase one word
    cmd(2'b11, 9'd10);
    wait_ready();
    desel();
    rdchk(9'd10, 16'hFFFF, "R11 erase word");

    // R9 program enable low
    pe = 0;
    cmd(2'b01, 9'd11);
    senddata(16'hBEEF);
    repeat (3) @(negedge clk);
    chk(do_oe == 0, "R9 no cycle with pe low", {15'd0, do_oe}, 16'd0);
    desel();
    rdchk(9'd11, 16'h0F1E, "R9 array unchanged, read allowed");
    pe = 1;

    // R2: deselect during the cycle, with sk toggling while deselected
    cmd(2'b01, 9'd12);
    senddata(16'h4242);
    @(negedge clk);
    cs = 0;
    for (int i = 0; i < 10; i++) tick(1);
    cs = 1;
    repeat (2) @(negedge clk);
    chk(do_oe && do_out, "R2 cycle finished while deselected", {14'd0, do_oe, do_out}, 16'h0003);
    desel();
    rdchk(9'd12, 16'h4242, "R2 data programmed");

    // R5: extra clocks after a complete instruction
    cmd(2'b01, 9'd13);
    senddata(16'h7777);
    tick(1); tick(1); tick(0);
    wait_ready();
    tick(1); tick(1); tick(0); tick(1);
    chk(do_oe && do_out, "R5 extra edges ignored", {14'd0, do_oe, do_out}, 16'h0003);
    desel();
    rdchk(9'd13, 16'h7777, "R5 data intact");

    // R4: zeros before start bit
    for (int i = 0; i < 5; i++) tick(0);
    chk(do_oe == 0, "R4 still waiting", {15'd0, do_oe}, 16'd0);
    rdchk(9'd13, 16'h7777, "R4 command after idle clocks");

    // R10 sequential read, word and byte mode
    cmd(2'b10, 9'd10);
    rd_bits(d);
    chk(d == 16'hFFFF, "R10 first word", d, 16'hFFFF);
    rd_bits(d);
    chk(d == 16'h0F1E, "R10 next word", d, 16'h0F1E);
    desel();
    org = 0;
    desel();
    cmd(2'b10, 9'd40);
    rd_bits(d);
    chk(d == 16'h005A, "R10 first byte", d, 16'h005A);
    rd_bits(d);
    chk(d == 16'h00C7, "R10 next byte", d, 16'h00C7);
    desel();
    org = 1;
    desel();

    // R1: aborted write
    tick(1); tick(0); tick(1); tick(0); tick(0); tick(1);
    desel();
    rdchk(9'd11, 16'h0F1E, "R1 aborted command no effect");

    // R11 write-all in byte mode, then erase-all in byte mode
    org = 0;
    desel();
    special(2'b01);
    senddata(16'h003C);
    wait_ready();
    desel();
    org = 1;
    desel();
    rdchk(9'd7, 16'h3C3C, "R11 write-all");
    org = 0;
    desel();
    cmd(2'b00, 9'b10_1100111);
    wait_ready();
    desel();
    org = 1;
    desel();
    rdchk(9'd7, 16'hFFFF, "R8 erase-all byte mode");

    // R11 disable
    special(2'b00);
    desel();
    cmd(2'b01, 9'd7);
    senddata(16'h0000);
    repeat (3) @(negedge clk);
    chk(do_oe == 0, "R11 disabled write no cycle", {15'd0, do_oe}, 16'd0);
    desel();
    rdchk(9'd7, 16'hFFFF, "R11 disabled write no change");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule